// File: doc/BRIEF.md
# SPI Register Access Master

This block performs single-register read and write transactions with an external peripheral over a four-wire SPI link in mode 0. The user side presents a request that carries a 5-bit register number, a direction flag and an 8-bit value to write. The block then runs one framed transfer and returns two bytes. The first is the status byte that the peripheral shifts out while it receives the command. The second is the data byte that comes back during the second byte time.

Each frame has exactly two bytes inside one chip-select-low window. The first byte is a command that carries the register number and the direction bit. The second byte is the write value for a write, or zero for a read. Every phase of the serial waveform is held for a fixed number of system-clock cycles, and each count is set by a parameter. These phases are the lead time from select to the first clock edge, the clock high time, the clock low time, and the recovery gap with select high. The defaults suit a 125 MHz system clock.

Top module: `spi_regio`

## Requirements
- R1: The command byte carries the register number in bits 7..3, 0 in bit 2, the direction in bit 1 (1 = write, 0 = read) and 0 in bit 0.
- R2: A frame sends the command byte and then one data byte in a single ss_n-low window. The data byte is req_wdata for a write and 0x00 for a read.
- R3: Bits go out most-significant first. mosi changes only while sclk is low and holds steady while sclk is high. The peripheral samples mosi on the rising edge of sclk.
- R4: While ready is high, ss_n is 1, sclk is 0 and mosi is 0. This is also the state after reset.
- R5: rsp_status returns the 8 bits sampled on miso at the first eight rising sclk edges, and rsp_rdata returns the bits sampled at the last eight. Both are sampled MSB first, and both are valid from the cycle in which done is high.
- R6: From ss_n falling to the first rising sclk takes exactly LEAD_CYC cycles (default 4). Every sclk high phase lasts HIGH_CYC cycles (default 3). Every sclk low phase, including the one before ss_n rises, lasts LOW_CYC cycles (default 3).
- R7: After ss_n rises it stays high for GAP_CYC cycles (default 25), and done goes high in the cycle after that.
- R8: A request is taken only when req_valid and ready are both high. ready is low for the whole frame and the recovery gap, and a request made while ready is low starts no frame.
- R9: done is a single-cycle pulse, and it occurs with ss_n high.
- R10: Each ss_n-low window contains exactly 16 rising sclk edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while ready is high |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 5 | Register number |
| req_wdata | input | 8 | Value to write |
| ready | output | 1 | Block is idle and will take a request |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| rsp_status | output | 8 | Byte received during the command byte |
| rsp_rdata | output | 8 | Byte received during the data byte |
| ss_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The bench uses a peripheral model that holds 32 registers, and it drives writes and then reads to register numbers 0, 31, 16 and 5. Reaching register 0 and register 31 shows that the register number lands in the right command bits at both ends of its range. Alternating data and status patterns (0xA5/0x5A, 0x81/0x7E, 0x00/0xFF) expose bit-order reversal, stuck bits, and any mix-up between the status byte and the read data. A read that follows a write of 0x00 over an earlier nonzero value shows that the write reached the peripheral. A burst of requests made while a frame is in progress shows that busy-time requests are dropped and do not corrupt the frame on the wire.

// File: rtl/spi_regio_pkg.sv
package spi_regio_pkg;

  localparam int ADDR_W     = 5;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 2 * BYTE_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_LOW,
    PH_GAP
  } phase_t;

  // Command byte: register number in the upper five bits, direction in bit 1.
  function automatic logic [BYTE_W-1:0] make_cmd(input logic [ADDR_W-1:0] addr,
                                                 input logic              wr);
    make_cmd = {addr, 1'b0, wr, 1'b0};
  endfunction

  // Full two-byte frame as shifted out, command first.
  function automatic logic [FRAME_BITS-1:0] make_frame(input logic [ADDR_W-1:0] addr,
                                                       input logic              wr,
                                                       input logic [BYTE_W-1:0] wdata);
    make_frame = {make_cmd(addr, wr), (wr ? wdata : {BYTE_W{1'b0}})};
  endfunction

endpackage

// File: rtl/spi_regio_timer.sv
module spi_regio_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= len - CNT_W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired = (cnt_q == '0);

  // Each phase starts from its full length (phase lengths, R6).
  p_timer_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(len) - CNT_W'(1)));

endmodule

// File: rtl/spi_regio_shift.sv
module spi_regio_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         rise,
  input  logic         fall,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx
);

  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= load_data;
      rx_q <= '0;
    end else begin
      if (rise) rx_q <= {rx_q[W-2:0], miso};
      if (fall) tx_q <= {tx_q[W-2:0], 1'b0};
    end
  end

  assign mosi = tx_q[W-1];
  assign rx   = rx_q;

  // Sampling and shifting never fall on the same edge (R3).
  p_edge_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));

  // Nothing is loaded during a bit phase (R8).
  p_load_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(rise || fall));

endmodule

// File: rtl/spi_regio.sv
module spi_regio #(
  parameter int LEAD_CYC = 4,
  parameter int HIGH_CYC = 3,
  parameter int LOW_CYC  = 3,
  parameter int GAP_CYC  = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [4:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       ready,
  output logic       done,
  output logic [7:0] rsp_status,
  output logic [7:0] rsp_rdata,
  output logic       ss_n,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  import spi_regio_pkg::*;

  localparam int MAX_A = (LEAD_CYC > HIGH_CYC) ? LEAD_CYC : HIGH_CYC;
  localparam int MAX_B = (LOW_CYC > GAP_CYC) ? LOW_CYC : GAP_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int BIT_W = $clog2(FRAME_BITS + 1);

  phase_t             phase_q;
  logic               ss_q, sclk_q, done_q;
  logic [BIT_W-1:0]   nfall_q;
  logic [BIT_W-1:0]   nrise_q;
  logic [BYTE_W-1:0]  stat_q, rdat_q;

  // Named events between the sequencer, the timer and the shifter.
  logic               start_ev, rise_ev, fall_ev, close_ev, finish_ev;
  logic               tm_load, tm_exp;
  logic [CNT_W-1:0]   tm_len;
  logic [FRAME_BITS-1:0] rx_bits;
  logic               last_bit;

  assign last_bit = (nfall_q == BIT_W'(FRAME_BITS));

  always_comb begin
    start_ev  = (phase_q == PH_IDLE) && req_valid;
    rise_ev   = tm_exp && ((phase_q == PH_LEAD) || ((phase_q == PH_LOW) && !last_bit));
    fall_ev   = tm_exp && (phase_q == PH_HIGH);
    close_ev  = tm_exp && (phase_q == PH_LOW) && last_bit;
    finish_ev = tm_exp && (phase_q == PH_GAP);
    tm_load   = start_ev || rise_ev || fall_ev || close_ev;
    if (start_ev)     tm_len = CNT_W'(LEAD_CYC);
    else if (rise_ev) tm_len = CNT_W'(HIGH_CYC);
    else if (fall_ev) tm_len = CNT_W'(LOW_CYC);
    else              tm_len = CNT_W'(GAP_CYC);
  end

  spi_regio_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tm_load),
    .len     (tm_len),
    .expired (tm_exp)
  );

  spi_regio_shift #(.W(FRAME_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ev),
    .load_data (make_frame(req_addr, req_write, req_wdata)),
    .rise      (rise_ev),
    .fall      (fall_ev),
    .miso      (miso),
    .mosi      (mosi),
    .rx        (rx_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ss_q    <= 1'b1;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      nfall_q <= '0;
      nrise_q <= '0;
      stat_q  <= '0;
      rdat_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ev) begin
        phase_q <= PH_LEAD;
        ss_q    <= 1'b0;
        nfall_q <= '0;
        nrise_q <= '0;
      end
      if (rise_ev) begin
        phase_q <= PH_HIGH;
        sclk_q  <= 1'b1;
        nrise_q <= nrise_q + BIT_W'(1);
      end
      if (fall_ev) begin
        phase_q <= PH_LOW;
        sclk_q  <= 1'b0;
        nfall_q <= nfall_q + BIT_W'(1);
      end
      if (close_ev) begin
        phase_q <= PH_GAP;
        ss_q    <= 1'b1;
      end
      if (finish_ev) begin
        phase_q <= PH_IDLE;
        done_q  <= 1'b1;
        stat_q  <= rx_bits[FRAME_BITS-1:BYTE_W];
        rdat_q  <= rx_bits[BYTE_W-1:0];
      end
    end
  end

  assign ready      = (phase_q == PH_IDLE);
  assign done       = done_q;
  assign rsp_status = stat_q;
  assign rsp_rdata  = rdat_q;
  assign ss_n       = ss_q;
  assign sclk       = sclk_q;

  // Idle line levels (R4).
  p_idle_levels_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ss_n && !sclk && !mosi));

  // Data held across the high phase (R3).
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // No clock outside the select window (R10).
  p_sclk_in_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !ss_n);

  // Exactly sixteen rising edges when select is released (R10).
  p_edge_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> (nrise_q == BIT_W'(FRAME_BITS)));

  // Busy while selected (R8).
  p_busy_no_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |-> !ready);

  // Done is one cycle wide and comes with select high (R9).
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ss_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ss_n);

endmodule

// File: tb/spi_regio_test.sv
module spi_regio_test;

  localparam int LEAD = 4, HIGH = 3, LOW = 3, GAP = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic ready, done, ss_n, sclk, mosi;
  logic [7:0] rsp_status, rsp_rdata;
  logic miso = 1'b0;

  always #4 clk = ~clk;

  spi_regio uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .ss_n(ss_n), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- peripheral model ----------------
  logic [7:0] sregs [32];
  logic [7:0] next_status = 8'h00;
  logic [7:0] s_out = '0, s_cmd = '0, s_dat = '0;
  logic [7:0] last_cmd = '0, last_dat = '0;
  int s_edges = 0, last_edges = 0, frames = 0;

  always @(negedge ss_n) begin
    s_edges = 0;
    s_out   = next_status;
    miso    = s_out[7];
  end

  always @(posedge sclk) if (!ss_n) begin
    if (s_edges < 8) s_cmd = {s_cmd[6:0], mosi};
    else             s_dat = {s_dat[6:0], mosi};
    s_edges++;
  end

  always @(negedge sclk) if (!ss_n) begin
    if (s_edges == 8) s_out = sregs[s_cmd[7:3]];
    else              s_out = {s_out[6:0], 1'b0};
    miso = s_out[7];
  end

  always @(posedge ss_n) if (rst_n) begin
    last_cmd   = s_cmd;
    last_dat   = s_dat;
    last_edges = s_edges;
    frames++;
    if (s_cmd[1]) sregs[s_cmd[7:3]] = s_dat;
  end

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] data;
    logic [7:0] status;
    logic [7:0] rdata;
  } exp_t;
  exp_t q[$];
  logic [7:0] shadow [32];
  int popped = 0;

  // Waveform timing tracker and result monitor.
  int  run = 0, tbad = 0;
  bit  first_rise = 1'b0;
  logic p_ss = 1'b1, p_sclk = 1'b0, p_done = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (ss_n !== p_ss) begin
      if (!ss_n) first_rise = 1'b1;
      else if (run != LOW) tbad++;          // R6 final low phase
      run = 0;
    end else if (!ss_n && (sclk !== p_sclk)) begin
      if (sclk) begin
        if (first_rise ? (run != LEAD) : (run != LOW)) tbad++;
        first_rise = 1'b0;
      end else if (run != HIGH) tbad++;
      run = 0;
    end
    if (done) begin
      exp_t e;
      chk(!p_done, "R9 single-cycle done", 32'(p_done), 0);
      chk(ss_n === 1'b1, "R9 done with ss_n high", 32'(ss_n), 1);
      chk(run == GAP, "R7 recovery gap", run, GAP);
      chk(tbad == 0, "R6 phase lengths", tbad, 0);
      tbad = 0;
      if (q.size() == 0) begin
        chk(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        e = q.pop_front();
        popped++;
        chk(last_cmd == e.cmd, "R1 command byte", last_cmd, e.cmd);
        chk(last_dat == e.data, "R2 data byte", last_dat, e.data);
        chk(last_edges == 16, "R10 edges per frame", last_edges, 16);
        chk(frames == popped, "R8 frame count", frames, popped);
        chk(rsp_status == e.status, "R5 status byte", rsp_status, e.status);
        chk(rsp_rdata == e.rdata, "R5 read data", rsp_rdata, e.rdata);
      end
    end
    run++;
    p_ss = ss_n; p_sclk = sclk; p_done = done;
  end

  // ---------------- driver ----------------
  task automatic txn(input bit wr, input logic [4:0] addr, input logic [7:0] wd,
                     input logic [7:0] st, input bit poke_busy);
    exp_t e;
    @(negedge clk);
    while (!ready) @(negedge clk);
    e.cmd    = 8'((32'(addr) * 8) + (wr ? 2 : 0));
    e.data   = wr ? wd : 8'h00;
    e.status = st;
    e.rdata  = shadow[addr];
    if (wr) shadow[addr] = wd;
    q.push_back(e);
    next_status = st;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke_busy) begin
      repeat (10) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 5'd7; req_wdata = 8'h33;
      repeat (4) begin
        @(negedge clk);
        chk(ready === 1'b0, "R8 ready low while busy", 32'(ready), 0);
      end
      req_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      sregs[i]  = 8'(i * 37 + 11);
      shadow[i] = 8'(i * 37 + 11);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ss_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R4 reset levels",
        {29'b0, ss_n, sclk, mosi}, 32'h4);
    chk(ready === 1'b1 && done === 1'b0, "R8 ready after reset",
        {30'b0, ready, done}, 32'h2);

    txn(1'b1, 5'd0,  8'hA5, 8'h81, 1'b0);
    txn(1'b1, 5'd31, 8'h5A, 8'h7E, 1'b0);
    txn(1'b0, 5'd0,  8'hEE, 8'h00, 1'b0);
    txn(1'b0, 5'd31, 8'h11, 8'hFF, 1'b0);
    txn(1'b1, 5'd16, 8'hFF, 8'h3C, 1'b1);
    txn(1'b0, 5'd16, 8'h00, 8'hC3, 1'b0);
    txn(1'b0, 5'd5,  8'h00, 8'h55, 1'b0);
    txn(1'b1, 5'd5,  8'h00, 8'hAA, 1'b0);
    txn(1'b0, 5'd5,  8'h99, 8'h0F, 1'b0);
    txn(1'b0, 5'd7,  8'h00, 8'hF0, 1'b0);

    @(negedge clk);
    chk(ss_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R4 idle levels",
        {29'b0, ss_n, sclk, mosi}, 32'h4);
    chk(frames == 10, "R8 total frames", frames, 10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule